// File: doc/BRIEF.md
# Reset-Button Hold Timer

This block measures how long an active-low reset button has been held down. The input comes from a pad and is asynchronous to the block, so it first passes through a synchronizer. The block then counts cycles of a 25 MHz reference clock for as long as the synchronized level stays low. Each count step is 40 ns. At the default width of 29 bits, the count spans about 21.4 seconds.

The count is read through a single 32-bit register. The value stays in place after the button is released, so software can read it at leisure and tell a brief tap from a long, factory-reset-style hold. A later press with no clear in between adds to the stored value. The counter never wraps: it stops at its largest value. Software empties it by writing a word with the top bit set. Deciding what a given duration means is left to software.

Top module: `rsthold_meter`

## Requirements
- R1: After reset the count is zero, `rd_valid` is low and `rd_data` is zero.
- R2: While the synchronized button level is low, the count rises by exactly one per clock. The synchronizer has two stages, so a low pulse lasting N clock periods leaves a count of N.
- R3: When the button is high, the count keeps its value indefinitely.
- R4: A new press without an intervening clear continues from the held value.
- R5: The count saturates at 2^CNT_W-1 and stays there while the button remains low.
- R6: A write with bit 31 of `wr_data` set clears the count to zero. A press after that counts from zero.
- R7: A write with bit 31 clear leaves the count unchanged, whatever the other bits hold.
- R8: When a clear and an increment fall in the same cycle, the clear wins and the count is zero after that edge.
- R9: A read strobe sampled on an edge raises `rd_valid` for the following cycle. In that cycle `rd_data[CNT_W-1:0]` holds the count and all bits above it read as zero. `rd_valid` is never high without a preceding strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| btn_n_async | input | 1 | Reset button level, active low, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bit 31 is the clear command |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Read data, count in the low CNT_W bits |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a read result |

## Verification
The assertions assume that the synchronizer output is the only source of increments. They also assume that a write is a single-cycle strobe whose bit 31 alone carries meaning. The bench drives the button, write and read strobes only on falling clock edges, holds each write for exactly one cycle, and lets every press settle through the two synchronizer stages before it reads. The bench instance uses a narrow counter width, so saturation and hold-at-maximum are reached within the run, while the register layout stays the same.

// File: rtl/rsthold_pkg.sv
package rsthold_pkg;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned CLR_BIT = 31;

  // Largest value representable in w bits (w < 32).
  function automatic logic [31:0] max_of(input int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

  // Next count: clear first, then saturating increment, otherwise hold.
  function automatic logic [31:0] step_count(input logic [31:0] cur,
                                             input logic        inc,
                                             input logic        clr,
                                             input int unsigned w);
    logic [31:0] nxt;
    if (clr)                        nxt = 32'd0;
    else if (inc && cur != max_of(w)) nxt = cur + 32'd1;
    else                            nxt = cur;
    return nxt;
  endfunction

  // Register image: count in the low bits, zeros above.
  function automatic logic [REG_W-1:0] reg_image(input logic [31:0] cnt,
                                                 input int unsigned w);
    return cnt & max_of(w);
  endfunction

endpackage

// File: rtl/rsthold_sync.sv
module rsthold_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= IDLE_VAL;
        end else begin
          if (s == 0) chain_q[s] <= async_i;
          else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/rsthold_counter.sv
module rsthold_counter #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      cnt_nxt;

  always_comb begin
    cnt_nxt = rsthold_pkg::step_count(32'(cnt_q), inc_i, clr_i, CNT_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rsthold_regif.sv
module rsthold_regif #(
  parameter int unsigned CNT_W = 29
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [rsthold_pkg::REG_W-1:0] wr_data,
  input  logic                          rd_en,
  input  logic [CNT_W-1:0]              cnt_i,
  output logic                          clr_o,
  output logic [rsthold_pkg::REG_W-1:0] rd_data,
  output logic                          rd_valid
);

  logic [rsthold_pkg::REG_W-1:0] rd_data_q;
  logic                          rd_valid_q;

  assign clr_o = wr_en & wr_data[rsthold_pkg::CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= rsthold_pkg::reg_image(32'(cnt_i), CNT_W);
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

endmodule

// File: rtl/rsthold_meter.sv
module rsthold_meter #(
  parameter int unsigned CNT_W       = 29,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        btn_n_async,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        rd_valid
);

  logic             btn_n_sync;
  logic             held_low;
  logic             clr_evt;
  logic [CNT_W-1:0] cnt_q;

  rsthold_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (btn_n_async),
    .sync_o  (btn_n_sync)
  );

  assign held_low = ~btn_n_sync;

  rsthold_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (held_low),
    .clr_i (clr_evt),
    .cnt_o (cnt_q)
  );

  rsthold_regif #(.CNT_W(CNT_W)) regif_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .cnt_i    (cnt_q),
    .clr_o    (clr_evt),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/rsthold_meter_chk.sv
module rsthold_meter_chk #(
  parameter int unsigned CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             held_low,
  input logic             clr_evt,
  input logic [CNT_W-1:0] cnt,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [31:0]      rd_data
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> cnt == '0); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && held_low) |=> cnt == '0); // R8

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (held_low && !clr_evt && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_low && !clr_evt) |=> $stable(cnt)); // R3

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr_evt) |=> cnt == CNT_MAX); // R5

  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R9

  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data >> CNT_W) == 32'd0); // R9

endmodule

bind rsthold_meter rsthold_meter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .held_low (held_low),
  .clr_evt  (clr_evt),
  .cnt      (cnt_q),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/rsthold_meter_tb_top.sv
module rsthold_meter_tb_top;

  localparam int CLK_PERIOD = 40;
  localparam int TB_CNT_W   = 8;
  localparam int SAT_VAL    = (1 << TB_CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        btn_n_async = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] val;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rsthold_meter #(.CNT_W(TB_CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .btn_n_async (btn_n_async),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: push the expected value, then strobe a read.
  task automatic do_read(input logic [31:0] exp, input string req);
    exp_t e;
    e.val = exp;
    e.req = req;
    exp_q.push_back(e);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  // Hold the button low for n clock periods, then let it settle.
  task automatic press(input int n);
    @(negedge clk) btn_n_async = 1'b0;
    repeat (n) @(negedge clk);
    btn_n_async = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: compare every read result with the head of the queue.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R9 spurious rd_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, rd_data, e.val);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    check("R1 rd_data after reset", rd_data, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_read(32'd0, "R1 count after reset");

    press(20);
    do_read(32'd20, "R2 count equals low cycles");
    repeat (30) @(negedge clk);
    do_read(32'd20, "R3 held after release");

    press(7);
    do_read(32'd27, "R4 second press accumulates");

    do_write(32'h7FFF_FFFF);
    repeat (2) @(negedge clk);
    do_read(32'd27, "R7 write without bit31 ignored");

    do_write(32'h8000_0000);
    do_read(32'd0, "R6 clear by bit31");
    press(13);
    do_read(32'd13, "R6 press after clear from zero");

    // R8: clear issued while the counter is incrementing.
    @(negedge clk) btn_n_async = 1'b0;
    repeat (5) @(negedge clk);
    wr_en = 1'b1;
    wr_data = 32'h8000_0000;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
    repeat (9) @(negedge clk);
    btn_n_async = 1'b1;
    repeat (4) @(negedge clk);
    do_read(32'd11, "R8 clear beats increment");

    do_write(32'h8000_0000);
    press(300);
    do_read(SAT_VAL, "R5 saturate at max, R9 upper bits zero");
    press(10);
    do_read(SAT_VAL, "R5 stays at max");
    do_write(32'hFFFF_FFFF);
    do_read(32'd0, "R6 clear from saturation");

    repeat (3) @(negedge clk);
    check("R9 all reads answered", exp_q.size(), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule